// File: doc/BRIEF.md
# Dual-Resolution Pulse-Width Modulator

This block generates a pulse-width-modulated output from a count-source enable. The enable marks the ticks to be counted. Two resolutions are available, and a mode input chooses between them.

- **Wide mode:** the whole setting word is the high time. The period is fixed at 2^W − 1 ticks, where W is the setting width (default 16).
- **Split mode:** the setting word is cut into two halves of H = W/2 bits each.
  - The lower half m is a prescaler, so each duty step lasts m+1 ticks.
  - The upper half n is the number of high steps within a frame of 2^H − 1 steps.

Each period starts with the output high for the programmed time, then holds it low for the rest. The block raises a one-cycle interrupt pulse when a period ends. A new setting or mode never disturbs a period in progress: both are captured only when the running period finishes, or at the moment the block is started. A setting with zero high time keeps the output low and suppresses the interrupt. Clearing the start input stops the block at once and zeroes its counters. Setting it again begins a fresh period.

Top module: `dual_pwm`

## Requirements
- R1: While reset is asserted, and after it is released with start low, `pwmOut` and `periodIrq` are both 0.
- R2: With `mode8`=0 the period lasts 2^W − 1 counted ticks. The output is high for the first n ticks, where n is the full setting (valid 0 to 2^W − 2).
- R3: With `mode8`=1, m = `setting[H-1:0]` and n = `setting[W-1:H]`. The period lasts (2^H − 1)·(m+1) ticks and the output is high for the first n·(m+1) ticks.
- R4: In wide mode a setting of 0 keeps `pwmOut` low and raises no interrupt.
- R5: In split mode an upper half of 0 keeps `pwmOut` low and raises no interrupt, whatever the prescaler half holds.
- R6: `setting` and `mode8` are captured only at start-up and at a period boundary. A change within a period does not alter that period.
- R7: Counters advance only in clock cycles where `countEn` is 1. With `countEn` low the output holds and no interrupt is raised.
- R8: When `start` is sampled 0, `pwmOut` is 0 from the next cycle and the counters reset. When `start` is set again, a full fresh period begins in the cycle after it is sampled, with the output high first.
- R9: `periodIrq` is a single-cycle pulse. It comes in the cycle after the last tick of a period whose high time was nonzero, which is the first cycle of the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run enable; 0 stops and clears the counters |
| mode8 | input | 1 | 0 = wide mode, 1 = split prescaler/duty mode |
| countEn | input | 1 | Count-source tick enable |
| setting | input | W | High time (wide) or {duty, prescaler} (split) |
| pwmOut | output | 1 | Modulated output |
| periodIrq | output | 1 | One-cycle pulse at each period end |

## Verification
The bench changes the setting and mode in the middle of a measured period. A design that applied the change immediately would give a period of the wrong length or high time. It exercises the extremes of the prescaler (0 and all ones) and a duty of a single tick. A design that counted the prescaler off by one would stretch every step and give the wrong period. It checks zero duty in both modes. A design that still fired interrupts there, or raised the output for one cycle, is caught. It also stops the block while the output is high, then restarts it. A design that let the output linger, or resumed the old count, would give a short or misaligned first period.

// File: rtl/dual_pwm_pkg.sv
package dual_pwm_pkg;
  typedef struct packed {
    logic clear;
    logic load;
    logic tickPre;
    logic tickMain;
  } pwmStrobe_t;
endpackage

// File: rtl/dual_pwm_dp.sv
module dual_pwm_dp
  import dual_pwm_pkg::*;
#(
  parameter int SET_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwmStrobe_t       strb,
  input  logic [SET_W-1:0] setting,
  input  logic             mode8,
  output logic             preLast,
  output logic             mainLast,
  output logic             highNow,
  output logic             dutyZero
);
  localparam int HALF_W = SET_W / 2;
  localparam logic [SET_W-1:0] WIDE_LAST = {{(SET_W-1){1'b1}}, 1'b0};
  localparam logic [SET_W-1:0] SPLIT_LAST = {{(SET_W-HALF_W){1'b0}}, {(HALF_W-1){1'b1}}, 1'b0};

  logic [SET_W-1:0]  actSet;
  logic              actMode8;
  logic [HALF_W-1:0] preCnt;
  logic [SET_W-1:0]  mainCnt;
  logic [HALF_W-1:0] dutyHalf;
  logic [HALF_W-1:0] preHalf;

  assign dutyHalf = actSet[SET_W-1:HALF_W];
  assign preHalf  = actSet[HALF_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actSet   <= '0;
      actMode8 <= 1'b0;
      preCnt   <= '0;
      mainCnt  <= '0;
    end else if (strb.clear) begin
      preCnt  <= '0;
      mainCnt <= '0;
    end else if (strb.load) begin
      actSet   <= setting;
      actMode8 <= mode8;
      preCnt   <= '0;
      mainCnt  <= '0;
    end else begin
      if (strb.tickPre) preCnt <= preLast ? '0 : preCnt + 1'b1;
      if (strb.tickMain) mainCnt <= mainCnt + 1'b1;
    end
  end

  always_comb begin
    if (actMode8) begin
      preLast  = (preCnt == preHalf);
      mainLast = (mainCnt == SPLIT_LAST);
      highNow  = (mainCnt < {{(SET_W-HALF_W){1'b0}}, dutyHalf});
      dutyZero = (dutyHalf == '0);
    end else begin
      preLast  = 1'b1;
      mainLast = (mainCnt == WIDE_LAST);
      highNow  = (mainCnt < actSet);
      dutyZero = (actSet == '0);
    end
  end
endmodule

// File: rtl/dual_pwm_ctl.sv
module dual_pwm_ctl
  import dual_pwm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       countEn,
  input  logic       preLast,
  input  logic       mainLast,
  input  logic       dutyZero,
  output pwmStrobe_t strb,
  output logic       running,
  output logic       periodIrq
);
  logic tick;
  logic periodEnd;

  always_comb begin
    tick          = running && start && countEn;
    periodEnd     = tick && preLast && mainLast;
    strb.clear    = !start;
    strb.load     = start && (!running || periodEnd);
    strb.tickPre  = tick;
    strb.tickMain = tick && preLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running   <= 1'b0;
      periodIrq <= 1'b0;
    end else begin
      running   <= start;
      periodIrq <= periodEnd && !dutyZero;
    end
  end
endmodule

// File: rtl/dual_pwm.sv
module dual_pwm
  import dual_pwm_pkg::*;
#(
  parameter int SET_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             mode8,
  input  logic             countEn,
  input  logic [SET_W-1:0] setting,
  output logic             pwmOut,
  output logic             periodIrq
);
  pwmStrobe_t strb;
  logic preLast, mainLast, highNow, dutyZero, running;

  dual_pwm_ctl ctl (
    .clk(clk), .rstN(rstN), .start(start), .countEn(countEn),
    .preLast(preLast), .mainLast(mainLast), .dutyZero(dutyZero),
    .strb(strb), .running(running), .periodIrq(periodIrq)
  );

  dual_pwm_dp #(.SET_W(SET_W)) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .setting(setting), .mode8(mode8),
    .preLast(preLast), .mainLast(mainLast), .highNow(highNow), .dutyZero(dutyZero)
  );

  assign pwmOut = running && highNow;
endmodule

// File: rtl/dual_pwm_chk.sv
module dual_pwm_chk (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic countEn,
  input logic running,
  input logic cfgLoad,
  input logic pwmOut,
  input logic periodIrq
);
  // R8
  stop_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !pwmOut);

  // R9
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    periodIrq |=> !periodIrq);

  // R9
  irq_running_chk: assert property (@(posedge clk) disable iff (!rstN)
    periodIrq |-> $past(start));

  // R6
  rise_at_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwmOut) |-> $past(cfgLoad));

  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && start && !countEn) |=> ($stable(pwmOut) && !periodIrq));
endmodule

bind dual_pwm dual_pwm_chk chk (
  .clk(clk), .rstN(rstN), .start(start), .countEn(countEn),
  .running(running), .cfgLoad(strb.load), .pwmOut(pwmOut), .periodIrq(periodIrq)
);

// File: tb/dual_pwm_test.sv
module dual_pwm_test;
  localparam int W = 8;
  localparam int WIDE_PER = 255;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic mode8 = 1'b0;
  logic countEn = 1'b1;
  logic slow = 1'b0;
  logic [W-1:0] setting = '0;
  logic pwmOut, periodIrq;

  int total = 0;
  int fails = 0;
  bit done = 0;

  typedef struct { int len; int hi; string req; } expItem_t;
  expItem_t expQ[$];

  dual_pwm #(.SET_W(W)) uut (
    .clk(clk), .rstN(rstN), .start(start), .mode8(mode8), .countEn(countEn),
    .setting(setting), .pwmOut(pwmOut), .periodIrq(periodIrq)
  );

  always #10 clk = ~clk;

  always @(negedge clk) countEn <= slow ? ~countEn : 1'b1;

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pushExp(int len, int hi, string req);
    expItem_t it;
    it.len = len; it.hi = hi; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic waitIrq();
    do @(negedge clk); while (!periodIrq);
  endtask

  // monitor: measures one period starting at the current irq sample, pops and compares
  task automatic monitorWindow(int changeAt, logic [W-1:0] newSet, logic newMode);
    int len = 0;
    int hi = 0;
    expItem_t it;
    do begin
      len++;
      if (pwmOut) hi++;
      if (len == changeAt) begin setting = newSet; mode8 = newMode; end
      @(negedge clk);
    end while (!periodIrq);
    it = expQ.pop_front();
    check(it.req, len, it.len);
    check(it.req, hi, it.hi);
  endtask

  task automatic firstPeriod(int expLen, int expHi, string req);
    int len = 0;
    int hi = 0;
    @(negedge clk);
    start = 1'b1;
    forever begin
      @(negedge clk);
      if (periodIrq) break;
      len++;
      if (pwmOut) hi++;
    end
    check(req, len, expLen);
    check(req, hi, expHi);
  endtask

  task automatic observeQuiet(int n, string req);
    int irqs = 0;
    int hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (periodIrq) irqs++;
      if (pwmOut) hi++;
    end
    check(req, irqs, 0);
    check(req, hi, 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      total++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1", pwmOut, 0);
    check("R1", periodIrq, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", pwmOut, 0);
    check("R1", periodIrq, 0);

    // R8 / R9: fresh start, irq right after the last tick
    setting = 8'd100;
    firstPeriod(WIDE_PER, 100, "R8");

    // R2 wide mode
    pushExp(WIDE_PER, 100, "R2");
    monitorWindow(0, '0, 1'b0);
    // R6 mid-period change ignored until boundary
    pushExp(WIDE_PER, 100, "R6");
    monitorWindow(60, 8'd254, 1'b0);
    pushExp(WIDE_PER, 254, "R2");
    monitorWindow(100, 8'd1, 1'b0);
    pushExp(WIDE_PER, 1, "R2");
    // R6 mode switch taken at boundary: n=5, m=2
    monitorWindow(10, 8'h52, 1'b1);
    // R3 split mode
    pushExp(45, 15, "R3");
    monitorWindow(5, 8'hE0, 1'b1);
    pushExp(15, 14, "R3");
    monitorWindow(3, 8'h7F, 1'b1);
    pushExp(240, 112, "R3");
    monitorWindow(0, '0, 1'b1);

    // R7 ticks on every other cycle: n=3, m=1 -> 30 ticks, 6 high
    setting = 8'h31;
    slow = 1'b1;
    waitIrq();
    pushExp(60, 12, "R7");
    monitorWindow(0, '0, 1'b1);
    slow = 1'b0;
    waitIrq();

    // R5 split mode zero duty
    setting = 8'h05;
    waitIrq();
    observeQuiet(400, "R5");

    // R8 stop
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check("R8", pwmOut, 0);
    check("R8", periodIrq, 0);

    // R4 wide mode zero setting
    mode8 = 1'b0;
    setting = 8'd0;
    start = 1'b1;
    observeQuiet(600, "R4");
    setting = 8'd40;
    waitIrq();
    pushExp(WIDE_PER, 40, "R6");
    monitorWindow(0, '0, 1'b0);

    // R8 stop while high, then restart fresh
    setting = 8'd200;
    waitIrq();
    repeat (20) @(negedge clk);
    check("R2", pwmOut, 1);
    start = 1'b0;
    @(negedge clk);
    check("R8", pwmOut, 0);
    firstPeriod(WIDE_PER, 200, "R8");

    done = 1;
    summary();
    $finish;
  end
endmodule